// File: doc/BRIEF.md
# Lockable PWM Channel with Oneshot Bursts

A single pulse-width-modulation channel. Software programs it through a simple register write/read port. A count register, a period register and a duty register set the waveform. A control register selects the run mode, the polarity, the alignment, the clock scaling and the burst length. In continuous mode the channel repeats its period until software disables it. In oneshot mode it emits a programmed number of periods (1 to 256), clears its own enable bit, parks the output at the idle level and raises a write-1-to-clear interrupt flag.

Period, duty and active polarity are held in live copies inside the counting engine. These live copies reload only at a period boundary, so the waveform never shows a half-updated setting. A lock bit in control holds the live copies across boundaries while software rewrites the shadow registers. Once the lock is released, period, duty and polarity switch together at the next boundary.

Register offsets are 0x00 count (read only), 0x04 period, 0x08 duty, 0x0C control, 0x10 interrupt flag and 0x14 interrupt enable. The control fields are:

- bit 0: enable
- bits 2:1: mode (0 = oneshot, 1 = continuous, 2 and 3 = idle)
- bit 3: active level (1 = active high)
- bit 4: idle level
- bit 5: centre alignment
- bit 6: lock
- bit 9: scaled clock
- bits 23:16: scale factor
- bits 31:24: burst length minus one

Reads are combinational from the address. Writes take effect at the clock edge where `reg_wr_i` is high. No data stream crosses the block, so every pin is a plain control or status signal.

Top module: `lpwm_channel`

## Requirements
- R1: After reset the output is low, `irq_o` is low, and the count, period, duty, control, interrupt flag and interrupt enable registers all read zero.
- R2: Period, duty, control and interrupt enable read back what was written. Mode value 1 is continuous and 0 is oneshot. Mode 2 or 3 with enable set keeps the output at the idle level (control bit 4).
- R3: In left alignment the count runs from 0 to period−1 and the active phase covers the first `duty` counts of each period.
- R4: With bit 3 set the active phase is high and the rest of the period is low; with bit 3 clear the levels swap. While disabled, the output equals control bit 4 from the cycle after the disabling write.
- R5: In centre alignment the active phase lasts `duty` counts and starts at count (period−duty)/2, rounded down.
- R6: Changes to period, duty or bit 3 reach the waveform only at the next period boundary. While control bit 6 is set, boundaries keep the old values. After bit 6 is cleared, all three switch together at the following boundary.
- R7: In oneshot mode, with bits 31:24 = N−1, the channel emits exactly N periods. It then clears control bit 0 and the output returns to the idle level.
- R8: Burst completion sets bit 0 of the interrupt flag (0x10). Writing 1 there clears it, and writing 0 leaves it unchanged. `irq_o` is the flag gated by bit 0 of the interrupt enable register (0x14).
- R9: With control bit 9 set and scale S in bits 23:16, each count step lasts 2·S clock cycles; S = 0 gives 512 cycles.
- R10: The count register at 0x00 restarts at 0 on the cycle after an enabling write and then advances once per step.
- R11: A duty of 0 gives no active phase, and a duty of at least the period gives an active phase over the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| pwm_o | output | 1 | Waveform output |
| irq_o | output | 1 | Burst-complete interrupt request |

## Verification
The bench builds the channel with a 16-bit count width (CNT_W = 16). The register map is unchanged at that width, but the waveform checks stay short. This keeps the slowest settings within the cycle budget: a scale factor of 0 (512-cycle steps) and a full 256-period burst with a one-count period. Boundary timing is checked by counting output levels over exact windows measured from the enabling write. This covers a duty rewrite just before a boundary, a lock held across a boundary, and the unlock taking effect one period later.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  localparam int REG_AW = 5;
  localparam int DATA_W = 32;

  localparam logic [REG_AW-1:0] OFF_CNT  = 5'h00;
  localparam logic [REG_AW-1:0] OFF_PER  = 5'h04;
  localparam logic [REG_AW-1:0] OFF_DUTY = 5'h08;
  localparam logic [REG_AW-1:0] OFF_CTRL = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_FLAG = 5'h10;
  localparam logic [REG_AW-1:0] OFF_IEN  = 5'h14;

  localparam logic [1:0] MODE_SHOT = 2'd0;
  localparam logic [1:0] MODE_CONT = 2'd1;

  typedef struct packed {
    logic [7:0] shots;
    logic [7:0] scale;
    logic [5:0] rsv_hi;
    logic       scl_sel;
    logic [1:0] rsv_mid;
    logic       lock;
    logic       center;
    logic       ipol;
    logic       dpol;
    logic [1:0] mode;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic              start_o,
  output logic              start_dpol_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] per_q, duty_q;
  logic             flag_q, ien_q;

  always_comb begin
    ctrl_w         = ctrl_t'(wdata_i);
    ctrl_w.rsv_hi  = '0;
    ctrl_w.rsv_mid = '0;
  end

  assign start_o      = wr_i && (addr_i == OFF_CTRL) && wdata_i[0] && !ctrl_q.en;
  assign start_dpol_o = wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= '0;
      duty_q <= '0;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == OFF_PER)  per_q  <= wdata_i[CNT_W-1:0];
      if (wr_i && addr_i == OFF_DUTY) duty_q <= wdata_i[CNT_W-1:0];
      if (wr_i && addr_i == OFF_IEN)  ien_q  <= wdata_i[0];
      if (wr_i && addr_i == OFF_CTRL) ctrl_q <= ctrl_w;
      if (done_i) ctrl_q.en <= 1'b0;
      flag_q <= (flag_q && !(wr_i && addr_i == OFF_FLAG && wdata_i[0])) || done_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFF_CNT:  rdata_o = DATA_W'(cnt_i);
      OFF_PER:  rdata_o = DATA_W'(per_q);
      OFF_DUTY: rdata_o = DATA_W'(duty_q);
      OFF_CTRL: rdata_o = ctrl_q;
      OFF_FLAG: rdata_o = DATA_W'(flag_q);
      OFF_IEN:  rdata_o = DATA_W'(ien_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign per_o  = per_q;
  assign duty_o = duty_q;
  assign irq_o  = flag_q && ien_q;

  // R7: burst completion drops the enable bit on the next cycle
  p_done_clears_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !ctrl_q.en);
  // R8: burst completion leaves the interrupt flag set
  p_done_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flag_q);
endmodule

// File: rtl/lpwm_tick.sv
module lpwm_tick #(
  parameter int SCALE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               sel_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);
  localparam int DIV_W = SCALE_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim    = (scale_i == '0) ? {DIV_W{1'b1}} : ({scale_i, 1'b0} - DIV_W'(1));
  assign tick_o = !sel_i || (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (start_i)        div_q <= '0;
    else if (div_q >= lim)   div_q <= '0;
    else                     div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/lpwm_engine.sv
module lpwm_engine
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_dpol_i,
  input  logic             tick_i,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, per_a, duty_a;
  logic             pol_a;
  logic [7:0]       shot_q;
  logic             run, step, last, active;
  logic [CNT_W-1:0] lo;
  logic [CNT_W:0]   hi_end;

  assign run  = ctrl_i.en && (ctrl_i.mode == MODE_SHOT || ctrl_i.mode == MODE_CONT);
  assign step = run && tick_i && !start_i;
  assign last = (per_a == '0) || (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, per_a});
  assign done_o = step && last && (ctrl_i.mode == MODE_SHOT) && (shot_q == ctrl_i.shots);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_a  <= '0;
      duty_a <= '0;
      pol_a  <= 1'b0;
      shot_q <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      shot_q <= '0;
      per_a  <= per_i;
      duty_a <= duty_i;
      pol_a  <= start_dpol_i;
    end else if (step) begin
      if (last) begin
        cnt_q <= '0;
        if (!ctrl_i.lock) begin
          per_a  <= per_i;
          duty_a <= duty_i;
          pol_a  <= ctrl_i.dpol;
        end
        if (ctrl_i.mode == MODE_SHOT && !done_o) shot_q <= shot_q + 8'd1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign lo     = (duty_a >= per_a) ? '0 : ((per_a - duty_a) >> 1);
  assign hi_end = {1'b0, lo} + {1'b0, duty_a};

  always_comb begin
    if (ctrl_i.center) active = (cnt_q >= lo) && ({1'b0, cnt_q} < hi_end);
    else               active = (cnt_q < duty_a);
  end

  assign pwm_o = run ? (active ? pol_a : !pol_a) : ctrl_i.ipol;
  assign cnt_o = cnt_q;

  // R3: the running count never reaches the live period
  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && per_a != '0) |-> (cnt_q < per_a));
  // R6: live settings move only on an enabling write or a boundary step
  p_live_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !(step && last)) |=> ($stable(per_a) && $stable(duty_a) && $stable(pol_a)));
endmodule

// File: rtl/lpwm_channel.sv
module lpwm_channel
  import lpwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              pwm_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] per_s, duty_s, cnt;
  logic             start, start_dpol, done, tick;

  lpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .cnt_i(cnt), .done_i(done),
    .ctrl_o(ctrl), .per_o(per_s), .duty_o(duty_s), .start_o(start),
    .start_dpol_o(start_dpol), .irq_o(irq_o)
  );

  lpwm_tick #(.SCALE_W(8)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .sel_i(ctrl.scl_sel),
    .scale_i(ctrl.scale), .tick_o(tick)
  );

  lpwm_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .start_dpol_i(start_dpol),
    .tick_i(tick), .ctrl_i(ctrl), .per_i(per_s), .duty_i(duty_s),
    .cnt_o(cnt), .done_o(done), .pwm_o(pwm_o)
  );
endmodule

// File: tb/lpwm_channel_bench.sv
module lpwm_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm, irq;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lpwm_channel #(.CNT_W(16)) u_lpwm_channel (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [15:0] per;
    logic [15:0] dut;
    logic [15:0] len;
    logic [15:0] hi;
    logic [15:0] first;
  } vec_t;

  // ctrl, period, duty, window, expected highs, expected first high (FFFF = none)
  localparam vec_t VECS [10] = '{
    '{32'h0000000B, 16'd10, 16'd3, 16'd10,   16'd3,   16'd0},      // R3
    '{32'h0000000B, 16'd8,  16'd0, 16'd8,    16'd0,   16'hFFFF},   // R11
    '{32'h0000000B, 16'd6,  16'd9, 16'd6,    16'd6,   16'd0},      // R11
    '{32'h0000002B, 16'd10, 16'd4, 16'd10,   16'd4,   16'd3},      // R5
    '{32'h0000002B, 16'd9,  16'd2, 16'd9,    16'd2,   16'd3},      // R5
    '{32'h00000013, 16'd10, 16'd3, 16'd10,   16'd7,   16'd3},      // R4
    '{32'h00000033, 16'd12, 16'd6, 16'd12,   16'd6,   16'd0},      // R4
    '{32'h0001020B, 16'd4,  16'd1, 16'd8,    16'd2,   16'd0},      // R9
    '{32'h0003020B, 16'd2,  16'd1, 16'd12,   16'd6,   16'd0},      // R9
    '{32'h0000020B, 16'd2,  16'd1, 16'd1024, 16'd512, 16'd0}       // R9
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic measure(input int n, output int hi, output int first);
    hi = 0; first = 'hFFFF;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) begin
        if (first == 'hFFFF) first = i;
        hi++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 pwm", pwm, 0);
    chk("R1 irq", irq, 0);
    rd_reg(5'h0C, d); chk("R1 ctrl", d, 0);
    rd_reg(5'h04, d); chk("R1 period", d, 0);
    rd_reg(5'h08, d); chk("R1 duty", d, 0);
    rd_reg(5'h00, d); chk("R1 count", d, 0);
    rd_reg(5'h10, d); chk("R1 flag", d, 0);
    rd_reg(5'h14, d); chk("R1 ien", d, 0);

    // table walk: R3 R4 R5 R9 R11
    for (int i = 0; i < 10; i++) begin
      wr_reg(5'h04, 32'(VECS[i].per));
      wr_reg(5'h08, 32'(VECS[i].dut));
      wr_reg(5'h0C, VECS[i].ctrl);
      measure(int'(VECS[i].len), h, f);
      chk($sformatf("R3/R4/R5/R9/R11 vec%0d highs", i), h, VECS[i].hi);
      chk($sformatf("R3/R4/R5/R9/R11 vec%0d first", i), f, VECS[i].first);
      wr_reg(5'h0C, VECS[i].ctrl & 32'hFFFF_FFFE);
      @(negedge clk);
      chk($sformatf("R4 idle level vec%0d", i), pwm, VECS[i].ctrl[4]);
    end

    // R2 readback and idle modes
    wr_reg(5'h04, 32'h1234); rd_reg(5'h04, d); chk("R2 period readback", d, 32'h1234);
    wr_reg(5'h08, 32'h0777); rd_reg(5'h08, d); chk("R2 duty readback", d, 32'h0777);
    wr_reg(5'h14, 32'h1);    rd_reg(5'h14, d); chk("R2 ien readback", d, 1);
    wr_reg(5'h04, 32'd4); wr_reg(5'h08, 32'd9);
    wr_reg(5'h0C, 32'h0000000D);
    rd_reg(5'h0C, d); chk("R2 ctrl readback", d, 32'h0000000D);
    measure(6, h, f); chk("R2 mode2 idle highs", h, 0);
    wr_reg(5'h0C, 32'h0000000C);

    // R10 count restarts and advances
    wr_reg(5'h04, 32'd10); wr_reg(5'h08, 32'd3);
    wr_reg(5'h0C, 32'h0000000B);
    rd_reg(5'h00, d); chk("R10 count at start", d, 0);
    rd_reg(5'h00, d); rd_reg(5'h00, d); rd_reg(5'h00, d);
    chk("R10 count after 3 steps", d, 3);
    wr_reg(5'h0C, 32'h0000000A);
    wr_reg(5'h0C, 32'h0000000B);
    rd_reg(5'h00, d); chk("R10 count restarts", d, 0);
    wr_reg(5'h0C, 32'h0000000A);

    // R6 duty change lands only at the next boundary
    wr_reg(5'h0C, 32'h0000000B);
    measure(4, h, f); chk("R6 first part highs", h, 3);
    wr_reg(5'h08, 32'd6);
    measure(5, h, f); chk("R6 old duty kept to boundary", h, 0);
    measure(10, h, f); chk("R6 new duty next period", h, 6);
    wr_reg(5'h0C, 32'h0000000A);

    // R6 lock holds across a boundary, unlock applies at the following one
    wr_reg(5'h08, 32'd3);
    wr_reg(5'h0C, 32'h0000000B);
    measure(2, h, f);
    wr_reg(5'h0C, 32'h0000004B);
    wr_reg(5'h08, 32'd1);
    wr_reg(5'h0C, 32'h00000053);
    measure(5, h, f); chk("R6 locked tail highs", h, 0);
    measure(10, h, f); chk("R6 locked period highs", h, 3);
    chk("R6 locked period first", f, 0);
    wr_reg(5'h0C, 32'h00000013);
    measure(9, h, f); chk("R6 unlock period keeps old", h, 2);
    measure(10, h, f); chk("R6 new settings highs", h, 9);
    chk("R6 new settings first", f, 1);
    wr_reg(5'h0C, 32'h00000012);

    // R7 R8 oneshot of 3 periods with interrupt enabled
    wr_reg(5'h04, 32'd4); wr_reg(5'h08, 32'd1);
    wr_reg(5'h0C, 32'h02000009);
    measure(12, h, f); chk("R7 burst highs", h, 3);
    measure(1, h, f); chk("R7 idle after burst", h, 0);
    chk("R8 irq raised", irq, 1);
    rd_reg(5'h0C, d); chk("R7 enable cleared", d, 32'h02000008);
    wr_reg(5'h10, 32'h0);
    rd_reg(5'h10, d); chk("R8 write 0 keeps flag", d, 1);
    wr_reg(5'h10, 32'h1);
    @(negedge clk);
    chk("R8 irq cleared", irq, 0);
    rd_reg(5'h10, d); chk("R8 flag cleared", d, 0);

    // R8 gating: flag without request
    wr_reg(5'h14, 32'h0);
    wr_reg(5'h0C, 32'h00000009);
    measure(4, h, f); chk("R7 single period highs", h, 1);
    measure(1, h, f);
    chk("R8 irq gated", irq, 0);
    rd_reg(5'h10, d); chk("R8 flag set while gated", d, 1);
    wr_reg(5'h10, 32'h1);

    // R7 longest burst
    wr_reg(5'h04, 32'd1); wr_reg(5'h08, 32'd1);
    wr_reg(5'h0C, 32'hFF000009);
    measure(256, h, f); chk("R7 256-period burst highs", h, 256);
    measure(1, h, f); chk("R7 idle after 256", h, 0);
    rd_reg(5'h0C, d); chk("R7 enable cleared after 256", d[0], 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule